// File: doc/BRIEF.md
# Programmable Interval Timer

A down-counting interval timer for interrupt generation. Software writes a period into a holding register and then issues a start command together with a mode bit. The counter is loaded from the holding register and decrements by one on every clock cycle where the tick enable, which comes from an oscillator divider, is high. The count reaching zero raises a one-cycle interrupt pulse.

There are two modes. In one-shot mode the timer stops at zero and stays idle until software issues another start. In square-wave mode the counter reloads itself from the holding register on the same tick that reaches zero. This gives a periodic interrupt, and a square-wave output that flips at each automatic reload. The holding register may be rewritten at any time. The count already in progress is left alone, and the new period is used at the next reload. A period value of zero means the longest interval, 2^W ticks.

Top module: `interval_timer`

## Requirements
- R1: After reset `irq` and `sq_out` are 0 and the timer is idle. Ticks arriving before any start command produce no interrupt.
- R2: The count changes only on cycles with `tick` high. After a start with period N, the interrupt follows the N-th tick, however many idle cycles separate the ticks.
- R3: `irq` goes high for exactly one cycle. It is high in the cycle after the clock edge at which the tick that takes the count to zero was sampled.
- R4: In one-shot mode (control bit 0 = 0), once the interrupt has fired no further interrupt occurs on later ticks until a new start command.
- R5: In square-wave mode (control bit 0 = 1), the counter reloads on the tick that reaches zero. Interrupts therefore repeat every N ticks without software action.
- R6: A start command clears `sq_out` to 0. In square-wave mode `sq_out` inverts at each automatic reload, so its period is 2N ticks.
- R7: A write to the holding register (address 0) while the timer is counting does not change the interval in progress. The new value applies at the next automatic reload or start.
- R8: A period value of 0 counts 2^W ticks.
- R9: Writes to address 1 are control writes. Bit 0 selects the mode. Bit 1 = 1 loads the counter from the holding register and runs. Bit 1 = 0 halts the timer, after which ticks produce no interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Write address: 0 = holding register, 1 = control |
| cfg_wdata | input | W | Write data |
| tick | input | 1 | Count enable from the oscillator divider |
| irq | output | 1 | Interrupt pulse on each zero crossing |
| sq_out | output | 1 | Square-wave output |

## Verification
Both outputs are registered. An interrupt and any change of `sq_out` caused by a tick appear in the cycle after the edge that sampled that tick. A start write clears `sq_out` at the edge that takes the write. The bench drives every stimulus at a falling edge and compares both outputs at the next falling edge, which is the first point where the edge's result is visible. A reference model in the bench counts remaining ticks from the written period and predicts each output for that same cycle. In the one-shot sweep, the tick number at which the interrupt appears is also compared with the written period.

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic         cfg_addr,
  input  logic [W-1:0] cfg_wdata,
  input  logic         tick,
  output logic         irq,
  output logic         sq_out
);
  localparam int CW = W + 1;

  logic [W-1:0]  hold_q;
  logic [CW-1:0] cnt_q;
  logic          mode_q;
  logic          run_q;

  wire [CW-1:0] reload = (hold_q == '0) ? {1'b1, {W{1'b0}}} : {1'b0, hold_q};
  wire          ctl_wr = cfg_we & cfg_addr;
  wire          hold_wr = cfg_we & ~cfg_addr;
  wire          at_one = (cnt_q == CW'(1));
  wire          hit = run_q & tick & at_one & ~ctl_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      cnt_q  <= '0;
      mode_q <= 1'b0;
      run_q  <= 1'b0;
      irq    <= 1'b0;
      sq_out <= 1'b0;
    end else begin
      irq <= hit;
      if (hold_wr) hold_q <= cfg_wdata;
      if (ctl_wr) begin
        mode_q <= cfg_wdata[0];
        run_q  <= cfg_wdata[1];
        if (cfg_wdata[1]) begin
          cnt_q  <= reload;
          sq_out <= 1'b0;
        end
      end else if (run_q && tick) begin
        if (at_one) begin
          if (mode_q) begin
            cnt_q  <= reload;
            sq_out <= ~sq_out;
          end else begin
            cnt_q <= '0;
            run_q <= 1'b0;
          end
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_we,
  input logic         cfg_addr,
  input logic [W-1:0] cfg_wdata,
  input logic         tick,
  input logic         irq,
  input logic         sq_out,
  input logic         run_q,
  input logic [W:0]   cnt_q
);
  wire start_wr = cfg_we & cfg_addr & cfg_wdata[1];

  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !tick && !cfg_we) |=> $stable(cnt_q));

  a_r3_irq_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(tick));

  a_r4_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> !irq);

  a_r6_sq_moves_with_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_out != $past(sq_out)) |-> (irq || $past(start_wr)));

  a_r8_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q != '0 && cnt_q <= {1'b1, {W{1'b0}}}));
endmodule

bind interval_timer interval_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .tick(tick), .irq(irq), .sq_out(sq_out),
  .run_q(run_q), .cnt_q(cnt_q)
);

// File: tb/interval_timer_bench.sv
`timescale 1ns/1ps
module interval_timer_bench;
  localparam int W = 4;
  localparam int MAXC = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic cfg_addr = 1'b0;
  logic [W-1:0] cfg_wdata = '0;
  logic tick = 1'b0;
  logic irq, sq_out;

  int errors = 0;
  int checks = 0;

  int  hold_m = 0;
  int  rem = 0;
  bit  mode_m = 0, run_m = 0, sq_m = 0, irq_m = 0;

  always #5 clk = ~clk;

  interval_timer #(.W(W)) u_interval_timer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tick(tick), .irq(irq), .sq_out(sq_out)
  );

  function automatic int effv(int h);
    return (h == 0) ? MAXC : h;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic outs(string req);
    check(req, "irq", int'(irq), int'(irq_m));
    check(req, "sq_out", int'(sq_out), int'(sq_m));
  endtask

  task automatic wr(bit a, int d, string req);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = W'(d); tick = 1'b0;
    @(posedge clk);
    irq_m = 0;
    if (!a) hold_m = d;
    else begin
      mode_m = d[0];
      run_m = d[1];
      if (d[1]) begin rem = effv(hold_m); sq_m = 0; end
    end
    @(negedge clk);
    cfg_we = 1'b0;
    outs(req);
  endtask

  task automatic step(bit t, string req);
    tick = t;
    @(posedge clk);
    irq_m = 0;
    if (run_m && t) begin
      rem--;
      if (rem == 0) begin
        irq_m = 1;
        if (mode_m) begin rem = effv(hold_m); sq_m = ~sq_m; end
        else run_m = 0;
      end
    end
    @(negedge clk);
    tick = 1'b0;
    outs(req);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1", "irq after reset", int'(irq), 0);
    check("R1", "sq_out after reset", int'(sq_out), 0);
    for (int i = 0; i < 5; i++) step(1, "R1");

    // R4 R8: one-shot sweep over every period, tick every cycle
    for (int n = 0; n < MAXC; n++) begin
      int seen;
      seen = 0;
      wr(0, n, "R8");
      wr(1, 2, "R4");
      for (int k = 1; k <= MAXC + 4; k++) begin
        step(1, (n == 0) ? "R8" : "R4");
        if (irq && seen == 0) seen = k;
      end
      check((n == 0) ? "R8" : "R2", "tick index of irq", seen, effv(n));
    end

    // R2: sparse ticks
    wr(0, 5, "R2");
    wr(1, 2, "R2");
    for (int k = 0; k < 24; k++) step((k % 3) == 2, "R2");

    // R5 R6 R3: square mode, several periods and tick spacings
    for (int p = 0; p < 4; p++) begin
      int n;
      n = (p == 0) ? 1 : (p == 1) ? 3 : (p == 2) ? 4 : 0;
      wr(0, n, "R6");
      wr(1, 3, "R6");
      for (int k = 0; k < 3 * effv(n) * 2 + 2; k++)
        step((p == 2) ? (k % 2 == 0) : 1'b1, "R5");
    end

    // R7: rewrite holding register mid-interval, square mode
    wr(0, 4, "R7");
    wr(1, 3, "R7");
    step(1, "R7");
    step(1, "R7");
    wr(0, 6, "R7");
    for (int k = 0; k < 16; k++) step(1, "R7");
    // R7: one-shot
    wr(0, 7, "R7");
    wr(1, 2, "R7");
    step(1, "R7");
    wr(0, 2, "R7");
    for (int k = 0; k < 10; k++) step(1, "R7");

    // R9: halt via control write with start bit clear
    wr(0, 3, "R9");
    wr(1, 3, "R9");
    step(1, "R9");
    wr(1, 1, "R9");
    for (int k = 0; k < 10; k++) step(1, "R9");
    wr(1, 2, "R9");
    for (int k = 0; k < 5; k++) step(1, "R9");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule